// File: doc/BRIEF.md
# Multi-Timer Interrupt Status Controller

This block sits between a bank of event-timer comparators and the interrupt fabric of a chip. Each comparator hands it a one-cycle fire pulse. For every timer the block keeps a status bit and turns fires into interrupts. Depending on the timer's configuration, an interrupt is a line held high (level type), a one-cycle pulse (edge type), or a 32-bit message write sent over a valid/ready request port (message route).

The comparators keep firing while a timer's interrupt enable or the global enable is off. In that state the status bit still records level-type fires, but nothing is delivered. When the timer enable or the global enable is turned back on, any recorded status is delivered at once. Software programs the block through a single-beat write port. That port holds a global enable, per-timer configuration words, per-timer 64-bit route registers, and a write-one-to-clear status register.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset every status bit is 0, every irq line is low and msg_valid is low.
- R2: A fire on a level-type timer sets its status bit. If both its enable and the global enable are on, its irq line goes high on the cycle after the fire and stays high.
- R3: A fire on a level-type timer whose enable or the global enable is off sets its status bit, and its irq line stays low.
- R4: A fire on an edge-type timer clears its status bit. If both enables are on, its irq line is high for exactly one cycle.
- R5: A config write that changes a timer from level type to edge type clears its status bit and lowers its line. This also holds when the message route is enabled.
- R6: A config write that turns a timer's enable from 0 to 1 while its status bit is set delivers the interrupt at once. For a level timer with the global enable on, the line is high on the next cycle.
- R7: A config write that turns a timer's enable from 1 to 0 lowers its line and keeps its status bit.
- R8: When the global enable goes from 0 to 1, every timer with its enable on and its status bit set is delivered again. When the global enable goes from 1 to 0, all lines are lowered and the status bits are kept.
- R9: A timer with the route bit set never drives its irq line. Each delivery instead queues a message with msg_addr equal to route bits 63:32 and msg_data equal to route bits 31:0. The request is held until msg_ready, and the lowest-numbered pending timer goes first.
- R10: Writing address 0x020 clears status bit n for each data bit n that is 1, and also lowers that timer's line. Data bits that are 0 have no effect.
- R11: Address map and field layout:
  - The global enable is bit 0 at address 0x010.
  - Timer n's config word is at 0x100 + 0x20*n, with level type at bit 1, enable at bit 2 and route at bit 14. Every other config bit is masked off on write.
  - The route low word is at config + 0x08 and the route high word is at config + 0x0C.
  - Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, single beat |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | 32 | Register write data |
| fire | input | 3 | Per-timer comparator fire pulse |
| irq | output | 3 | Per-timer interrupt line |
| status | output | 3 | Per-timer interrupt status bits |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message write request accepted |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The assertions assume the following about the inputs:
- A fire and a status clear for the same timer never fall in the same cycle as a config write that changes that timer's type.
- Once msg_valid is raised, msg_ready is not required within any bound.

The directed stimulus follows these rules:
- It issues writes and fires in separate cycles, except where a scenario needs two fires to coincide.
- It holds msg_ready low for several cycles before granting, so that the held request and the queue order can be observed.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

  localparam int CFG_LVL_BIT = 1;
  localparam int CFG_EN_BIT  = 2;
  localparam int CFG_RTE_BIT = 14;

  typedef struct packed {
    logic route;
    logic en;
    logic lvl;
  } tmr_cfg_t;

  function automatic tmr_cfg_t cfg_unpack(input logic [31:0] w);
    tmr_cfg_t c;
    c.route = w[CFG_RTE_BIT];
    c.en    = w[CFG_EN_BIT];
    c.lvl   = w[CFG_LVL_BIT];
    return c;
  endfunction

endpackage

// File: rtl/tmr_irq_slice.sv
module tmr_irq_slice
  import tmr_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire_i,
  input  logic                cfg_wr_i,
  input  logic                rte_lo_wr_i,
  input  logic                rte_hi_wr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                glb_en_i,
  input  logic                glb_rise_i,
  input  logic                glb_fall_i,
  input  logic                stat_clr_i,
  input  logic                grant_i,
  output logic                status_o,
  output logic                irq_o,
  output logic                pend_o,
  output logic [2*DATA_W-1:0] route_o
);

  tmr_cfg_t            cfg_q, cfg_new, cfg_eff;
  logic                status_q, status_d;
  logic                hold_q, hold_d;
  logic                pulse_q, pulse_d;
  logic                pend_q, pend_d;
  logic [2*DATA_W-1:0] rte_q;
  logic                replay, msg_req;

  // next-state: ordered steps within one cycle
  always_comb begin
    cfg_new  = cfg_unpack(wr_data_i);
    cfg_eff  = cfg_wr_i ? cfg_new : cfg_q;
    status_d = status_q;
    hold_d   = hold_q;
    pulse_d  = 1'b0;
    msg_req  = 1'b0;
    // level -> edge: drop line and status before new config applies
    if (cfg_wr_i && cfg_q.lvl && !cfg_new.lvl) begin
      status_d = 1'b0;
      hold_d   = 1'b0;
    end
    if (cfg_wr_i && cfg_q.en && !cfg_new.en) hold_d = 1'b0;
    if (glb_fall_i) hold_d = 1'b0;
    if (stat_clr_i) begin
      status_d = 1'b0;
      hold_d   = 1'b0;
    end
    replay = status_d &&
             ((cfg_wr_i && !cfg_q.en && cfg_new.en) || (glb_rise_i && cfg_eff.en));
    if (fire_i || replay) begin
      status_d = cfg_eff.lvl;
      if (cfg_eff.en && glb_en_i) begin
        if (cfg_eff.route)    msg_req = 1'b1;
        else if (cfg_eff.lvl) hold_d  = 1'b1;
        else                  pulse_d = 1'b1;
      end else if (!cfg_eff.route) begin
        hold_d = 1'b0;
      end
    end
    pend_d = (pend_q && !grant_i) || msg_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      status_q <= 1'b0;
      hold_q   <= 1'b0;
      pulse_q  <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (cfg_wr_i) cfg_q <= cfg_new;
      status_q <= status_d;
      hold_q   <= hold_d;
      pulse_q  <= pulse_d;
      pend_q   <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rte_q <= '0;
    end else begin
      if (rte_lo_wr_i) rte_q[DATA_W-1:0]        <= wr_data_i;
      if (rte_hi_wr_i) rte_q[2*DATA_W-1:DATA_W] <= wr_data_i;
    end
  end

  assign status_o = status_q;
  assign irq_o    = (hold_q || pulse_q) && !cfg_q.route;
  assign pend_o   = pend_q;
  assign route_o  = rte_q;

  assert_level_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && cfg_q.lvl && !cfg_wr_i && !stat_clr_i) |=> status_q);

  assert_edge_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !cfg_q.lvl && !cfg_wr_i) |=> !status_q);

  assert_lvl_to_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && cfg_q.lvl && !cfg_new.lvl) |=> (!status_q && !irq_o));

  assert_enable_replay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && !cfg_q.en && cfg_new.en && cfg_new.lvl && cfg_q.lvl && !cfg_new.route
     && status_q && glb_en_i && !stat_clr_i) |=> irq_o);

  assert_off_line_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.en |-> !hold_q);

  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_i && !fire_i) |=> !status_q);

endmodule

// File: rtl/tmr_msg_arb.sv
module tmr_msg_arb #(
  parameter int NUM_TMR = 3,
  parameter int DATA_W  = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_TMR-1:0]                pend_i,
  input  logic [NUM_TMR-1:0][2*DATA_W-1:0]  route_i,
  input  logic                              ready_i,
  output logic                              valid_o,
  output logic [DATA_W-1:0]                 addr_o,
  output logic [DATA_W-1:0]                 data_o,
  output logic [NUM_TMR-1:0]                grant_o
);

  logic [NUM_TMR-1:0] sel;

  // fixed priority: lowest index wins
  always_comb begin
    sel    = '0;
    addr_o = '0;
    data_o = '0;
    for (int i = NUM_TMR - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
        addr_o = route_i[i][2*DATA_W-1:DATA_W];
        data_o = route_i[i][DATA_W-1:0];
      end
    end
  end

  assign valid_o = |pend_i;
  assign grant_o = ready_i ? sel : '0;

  assert_msg_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> valid_o);

  assert_grant_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int NUM_TMR = 3,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [NUM_TMR-1:0] fire,
  output logic [NUM_TMR-1:0] irq,
  output logic [NUM_TMR-1:0] status,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [DATA_W-1:0]  msg_addr,
  output logic [DATA_W-1:0]  msg_data
);

  localparam logic [ADDR_W-1:0] GLB_ADDR   = ADDR_W'('h010);
  localparam logic [ADDR_W-1:0] STS_ADDR   = ADDR_W'('h020);
  localparam int                TMR_BASE   = 'h100;
  localparam int                TMR_STRIDE = 'h20;
  localparam int                RTE_LO_OFS = 'h08;
  localparam int                RTE_HI_OFS = 'h0C;

  logic glb_q, glb_d, glb_wr, glb_rise, glb_fall, sts_wr;
  logic [NUM_TMR-1:0]               cfg_wr, rlo_wr, rhi_wr, pend, grant;
  logic [NUM_TMR-1:0][2*DATA_W-1:0] route;

  always_comb begin
    glb_wr   = wr_en && (wr_addr == GLB_ADDR);
    sts_wr   = wr_en && (wr_addr == STS_ADDR);
    glb_d    = glb_wr ? wr_data[0] : glb_q;
    glb_rise = glb_d && !glb_q;
    glb_fall = !glb_d && glb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glb_q <= 1'b0;
    else if (glb_wr) glb_q <= glb_d;
  end

  for (genvar n = 0; n < NUM_TMR; n++) begin : g_tmr
    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(TMR_BASE + n * TMR_STRIDE);
    assign cfg_wr[n] = wr_en && (wr_addr == CFG_A);
    assign rlo_wr[n] = wr_en && (wr_addr == CFG_A + ADDR_W'(RTE_LO_OFS));
    assign rhi_wr[n] = wr_en && (wr_addr == CFG_A + ADDR_W'(RTE_HI_OFS));

    tmr_irq_slice #(.DATA_W(DATA_W)) u_slice (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire_i      (fire[n]),
      .cfg_wr_i    (cfg_wr[n]),
      .rte_lo_wr_i (rlo_wr[n]),
      .rte_hi_wr_i (rhi_wr[n]),
      .wr_data_i   (wr_data),
      .glb_en_i    (glb_d),
      .glb_rise_i  (glb_rise),
      .glb_fall_i  (glb_fall),
      .stat_clr_i  (sts_wr && wr_data[n]),
      .grant_i     (grant[n]),
      .status_o    (status[n]),
      .irq_o       (irq[n]),
      .pend_o      (pend[n]),
      .route_o     (route[n])
    );
  end

  tmr_msg_arb #(.NUM_TMR(NUM_TMR), .DATA_W(DATA_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_i  (pend),
    .route_i (route),
    .ready_i (msg_ready),
    .valid_o (msg_valid),
    .addr_o  (msg_addr),
    .data_o  (msg_data),
    .grant_o (grant)
  );

  assert_glb_off_lines_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    glb_fall |=> (irq == '0));

endmodule

// File: tb/tmr_irq_ctrl_tb_top.sv
module tmr_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  fire = '0;
  logic [2:0]  irq, status;
  logic        msg_valid, msg_ready = 1'b0;
  logic [31:0] msg_addr, msg_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fire(fire), .irq(irq), .status(status), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fire_t(input logic [2:0] m);
    @(negedge clk);
    fire = m;
    @(negedge clk);
    fire = '0;
  endtask

  task automatic t_reset;
    chk("R1 irq", irq, 0);
    chk("R1 status", status, 0);
    chk("R1 msg_valid", msg_valid, 0);
  endtask

  task automatic t_level;
    wr(12'h010, 1);
    wr(12'h100, 32'h6);
    fire_t(3'b001);
    chk("R2 irq0 high", irq[0], 1);
    chk("R2 status0", status[0], 1);
    repeat (3) @(negedge clk);
    chk("R2 irq0 held", irq[0], 1);
    wr(12'h020, 0);
    chk("R10 zero no effect", {status[0], irq[0]}, 2'b11);
    wr(12'h020, 1);
    chk("R10 clear", {status[0], irq[0]}, 2'b00);
  endtask

  task automatic t_disabled;
    wr(12'h120, 32'h2);
    fire_t(3'b010);
    chk("R3 status1", status[1], 1);
    chk("R3 irq1 low", irq[1], 0);
    wr(12'h120, 32'h6);
    chk("R6 replay", irq[1], 1);
    wr(12'h120, 32'h2);
    chk("R7 line low status kept", {status[1], irq[1]}, 2'b10);
    wr(12'h010, 0);
    wr(12'h120, 32'h6);
    chk("R3 global off no line", irq[1], 0);
    wr(12'h010, 1);
    chk("R8 global replay", irq[1], 1);
    wr(12'h010, 0);
    chk("R8 global off lowers", {status[1], irq[1]}, 2'b10);
    wr(12'h010, 1);
    chk("R8 replay again", irq[1], 1);
    wr(12'h020, 2);
    chk("R10 clear t1", {status[1], irq[1]}, 2'b00);
  endtask

  task automatic t_edge;
    wr(12'h140, 32'h4);
    fire_t(3'b100);
    chk("R4 pulse", irq[2], 1);
    chk("R4 status clear", status[2], 0);
    @(negedge clk);
    chk("R4 pulse one cycle", irq[2], 0);
    wr(12'h010, 0);
    fire_t(3'b100);
    chk("R4 no pulse global off", irq[2], 0);
    wr(12'h010, 1);
  endtask

  task automatic t_l2e;
    wr(12'h100, 32'h6);
    fire_t(3'b001);
    chk("R2 pre", irq[0], 1);
    wr(12'h100, 32'h4);
    chk("R5 level to edge", {status[0], irq[0]}, 2'b00);
    wr(12'h100, 32'h4002);
    fire_t(3'b001);
    chk("R5 route status set", status[0], 1);
    wr(12'h100, 32'h4000);
    chk("R5 route cleared", status[0], 0);
    wr(12'h100, 32'hFFFF_BFF9);
    fire_t(3'b001);
    chk("R11 masked bits ignored", {status[0], irq[0], msg_valid}, 3'b000);
    wr(12'h0C0, 32'hFFFF_FFFF);
    fire_t(3'b001);
    chk("R11 unmapped ignored", {status[0], irq[0]}, 2'b00);
  endtask

  task automatic t_route;
    wr(12'h148, 32'hDEAD_BEEF);
    wr(12'h14C, 32'h0FEE_0000);
    wr(12'h128, 32'h1111_2222);
    wr(12'h12C, 32'h0FEE_1000);
    wr(12'h140, 32'h4004);
    fire_t(3'b100);
    chk("R9 no line", irq[2], 0);
    chk("R9 valid", msg_valid, 1);
    chk("R9 addr", msg_addr, 32'h0FEE_0000);
    chk("R9 data", msg_data, 32'hDEAD_BEEF);
    repeat (2) @(negedge clk);
    chk("R9 held", msg_valid, 1);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    chk("R9 consumed", msg_valid, 0);
    wr(12'h120, 32'h4006);
    fire_t(3'b110);
    chk("R9 no line level route", irq[1], 0);
    chk("R9 first low index", msg_addr, 32'h0FEE_1000);
    chk("R9 first data", msg_data, 32'h1111_2222);
    msg_ready = 1'b1;
    @(negedge clk);
    chk("R9 second", {msg_valid, msg_addr}, {1'b1, 32'h0FEE_0000});
    @(negedge clk);
    msg_ready = 1'b0;
    chk("R9 drained", msg_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_disabled();
    t_edge();
    t_l2e();
    t_route();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule